// File: doc/BRIEF.md
# Wiper Step Command Sequencer

This block is the host-side master for a stepped digital potentiometer that is driven over three control lines: an active-low select, an active-low step strobe and a direction level. Logic elsewhere on the chip hands it one command through a valid/ready handshake. A command holds a step count, a direction, a keep-the-result flag and a homing flag. The sequencer turns the command into a select window in which the strobe is pulsed once per step. It then releases select, waits out the recovery time the potentiometer needs, and gives a one-cycle completion pulse.

Every minimum time is a parameter counted in system clock cycles. These are the select-to-first-strobe lead, the direction lead before a strobe, the low and high strobe widths, the gap from the last strobe edge to release, and the recovery gap after release. The keep-the-result choice is made by the strobe level at the moment select is released: strobe high keeps the position, strobe low discards it. For that reason a no-keep command leaves the strobe low after its final step instead of raising it again.

A homing command sends the largest useful number of down steps without keeping the result. Since the wiper stops at its end stop, it always finishes at position 0, and later relative moves then become absolute. Requested counts above the number of useful steps are clipped, because the wiper saturates at either end.

Top module: `wiper_cmd_seq`

## Requirements
- R1: While reset is asserted and after it is released, `pot_cs_n` and `pot_inc_n` are 1, `pot_up` is 0, `done` is 0 and `cmd_ready` is 1.
- R2: A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the cycle after acceptance until the completion pulse, and a command held valid during that time has no effect on the pins.
- R3: Each falling edge of `pot_inc_n` comes at least CS_LEAD_CYC cycles after `pot_cs_n` fell and at least DIR_LEAD_CYC cycles after `pot_up` last changed. `pot_up` changes only in a cycle where `pot_inc_n` was already 1 and stays 1. `pot_up` = 1 means step up.
- R4: Every low phase of `pot_inc_n` while selected lasts at least STROBE_LO_CYC cycles, and every high phase before a further falling edge lasts at least STROBE_HI_CYC cycles. A command with count N gives exactly min(N, TAP_LAST) falling edges.
- R5: `pot_cs_n` rises at least REL_GAP_CYC cycles after the last `pot_inc_n` edge of the select window. It rises with `pot_inc_n` = 1 when `cmd_store` was 1 (keep) and with `pot_inc_n` = 0 when it was 0 (discard).
- R6: After `pot_cs_n` rises it stays 1 for at least RECOVER_CYC cycles before falling again. `done` is a single-cycle pulse raised with `pot_cs_n` = 1 once that recovery wait ends, and a new command can be accepted in that same cycle.
- R7: A command with `cmd_home` = 1 ignores `cmd_steps`, `cmd_up` and `cmd_store`. It gives TAP_LAST down steps and releases with `pot_inc_n` = 0 (discard).
- R8: A step count above TAP_LAST is clipped to TAP_LAST steps.
- R9: A zero-step command with keep selects the device, gives no strobe, and releases with `pot_inc_n` = 1. A zero-step command without keep leaves all three pins untouched and gives `done` two cycles after acceptance.
- R10: `pot_inc_n` never falls while `pot_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_steps | input | STEP_W | Requested number of steps |
| cmd_up | input | 1 | 1 = step up, 0 = step down |
| cmd_store | input | 1 | 1 = keep the final position on release |
| cmd_home | input | 1 | 1 = homing command (overrides the other fields) |
| done | output | 1 | One-cycle completion pulse |
| pot_cs_n | output | 1 | Active-low select to the potentiometer |
| pot_inc_n | output | 1 | Step strobe, active on its falling edge |
| pot_up | output | 1 | Direction level to the potentiometer |

## Verification
The completion pulse of one command and the acceptance of the next can fall in the same cycle. The bench provokes this by holding a second command valid from the moment the first is taken. It judges that `cmd_ready` and `done` are both high in that one cycle and that the held command did not move the model wiper early. It also checks that the next select still respects the recovery gap. A pin-level model of the potentiometer measures every strobe, direction and select interval and tracks the wiper and kept positions, so each command is judged on its effect and its timing together.

// File: rtl/wseq_pkg.sv
`timescale 1ns/1ps
package wseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SETUP_DIR,
    ST_INC_LOW,
    ST_INC_HIGH,
    ST_HOLD,
    ST_DESELECT,
    ST_COOLDOWN
  } wseq_state_e;

  typedef struct packed {
    logic cs_n;
    logic inc_n;
  } wseq_pins_t;

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels belonging to each state; keep decides the strobe level at release.
  function automatic wseq_pins_t pins_for(input wseq_state_e st, input logic keep);
    wseq_pins_t p;
    p.cs_n  = 1'b1;
    p.inc_n = 1'b1;
    case (st)
      ST_SELECT, ST_SETUP_DIR, ST_INC_HIGH: p.cs_n = 1'b0;
      ST_INC_LOW: begin
        p.cs_n  = 1'b0;
        p.inc_n = 1'b0;
      end
      ST_HOLD: begin
        p.cs_n  = 1'b0;
        p.inc_n = keep;
      end
      ST_DESELECT: p.inc_n = keep;
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/wseq_rst_sync.sv
`timescale 1ns/1ps
module wseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/wseq_timer.sv
`timescale 1ns/1ps
module wseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  assign expired  = (count_q == '0);
  assign count_en = load | ~expired;

  always_comb begin
    if (load) count_d = load_val;
    else      count_d = count_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

endmodule

// File: rtl/wseq_steps.sv
`timescale 1ns/1ps
module wseq_steps #(
  parameter int STEP_W   = 8,
  parameter int TAP_LAST = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] req_steps,
  input  logic              req_home,
  input  logic              load,
  input  logic              dec,
  output logic              req_zero,
  output logic              rem_zero,
  output logic              rem_last
);

  localparam int CW = $clog2(TAP_LAST + 1);

  logic [CW-1:0] clip_steps;
  logic [CW-1:0] rem_q;
  logic [CW-1:0] rem_d;
  logic          rem_en;

  // Saturating wiper: more than TAP_LAST steps can never change the result.
  always_comb begin
    if (req_home)                          clip_steps = CW'(TAP_LAST);
    else if (32'(req_steps) > TAP_LAST)    clip_steps = CW'(TAP_LAST);
    else                                   clip_steps = CW'(req_steps);
  end

  assign req_zero = (clip_steps == '0);
  assign rem_zero = (rem_q == '0);
  assign rem_last = (rem_q == CW'(1));
  assign rem_en   = load | dec;

  always_comb begin
    if (load) rem_d = clip_steps;
    else      rem_d = rem_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rem_q) <= TAP_LAST);

  a_r4_no_step_past_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !rem_zero);

endmodule

// File: rtl/wseq_fsm.sv
`timescale 1ns/1ps
module wseq_fsm
  import wseq_pkg::*;
#(
  parameter int TW            = 8,
  parameter int CS_LEAD_CYC   = 25,
  parameter int DIR_LEAD_CYC  = 725,
  parameter int STROBE_LO_CYC = 250,
  parameter int STROBE_HI_CYC = 250,
  parameter int REL_GAP_CYC   = 250,
  parameter int RECOVER_CYC   = 5000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_up,
  input  logic          cmd_store,
  input  logic          cmd_home,
  input  logic          req_zero,
  input  logic          tmr_expired,
  input  logic          rem_zero,
  input  logic          rem_last,
  output logic          cmd_ready,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          steps_load,
  output logic          steps_dec,
  output logic          done,
  output logic          cs_n,
  output logic          inc_n,
  output logic          up
);

  localparam logic [TW-1:0] L_SEL  = TW'(CS_LEAD_CYC - 1);
  localparam logic [TW-1:0] L_DIR  = TW'(DIR_LEAD_CYC - 1);
  localparam logic [TW-1:0] L_LOW  = TW'(STROBE_LO_CYC - 1);
  localparam logic [TW-1:0] L_HIGH = TW'(STROBE_HI_CYC - 1);
  localparam logic [TW-1:0] L_HOLD = TW'(REL_GAP_CYC - 1);
  localparam logic [TW-1:0] L_COOL = TW'(RECOVER_CYC - 1);

  wseq_state_e state_q, state_d;
  logic        keep_q, keep_d;
  logic        dir_q, dir_d;
  wseq_pins_t  pins_d;
  logic        done_d;
  logic        up_en;

  assign cmd_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    keep_d     = keep_q;
    dir_d      = dir_q;
    tmr_val    = '0;
    steps_load = 1'b0;
    steps_dec  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          steps_load = 1'b1;
          keep_d     = cmd_store & ~cmd_home;
          dir_d      = cmd_up & ~cmd_home;
          if (req_zero && !keep_d) begin
            state_d = ST_COOLDOWN;
            tmr_val = '0;
          end else begin
            state_d = ST_SELECT;
            tmr_val = L_SEL;
          end
        end
      end
      ST_SELECT: begin
        if (tmr_expired) begin
          state_d = ST_SETUP_DIR;
          tmr_val = L_DIR;
        end
      end
      ST_SETUP_DIR: begin
        if (tmr_expired) begin
          if (rem_zero) begin
            state_d = ST_HOLD;
            tmr_val = L_HOLD;
          end else begin
            state_d = ST_INC_LOW;
            tmr_val = L_LOW;
          end
        end
      end
      ST_INC_LOW: begin
        if (tmr_expired) begin
          steps_dec = 1'b1;
          // Discard: the strobe stays low after the final step up to release.
          if (rem_last && !keep_q) begin
            state_d = ST_HOLD;
            tmr_val = L_HOLD;
          end else begin
            state_d = ST_INC_HIGH;
            tmr_val = L_HIGH;
          end
        end
      end
      ST_INC_HIGH: begin
        if (tmr_expired) begin
          if (rem_zero) begin
            state_d = ST_HOLD;
            tmr_val = L_HOLD;
          end else begin
            state_d = ST_INC_LOW;
            tmr_val = L_LOW;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_expired) begin
          state_d = ST_DESELECT;
          tmr_val = '0;
        end
      end
      ST_DESELECT: begin
        if (tmr_expired) begin
          state_d = ST_COOLDOWN;
          tmr_val = L_COOL;
        end
      end
      ST_COOLDOWN: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign pins_d   = pins_for(state_d, keep_d);
  assign done_d   = (state_q == ST_COOLDOWN) && tmr_expired;
  assign up_en    = (state_d == ST_SETUP_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      keep_q  <= 1'b0;
      dir_q   <= 1'b0;
      cs_n    <= 1'b1;
      inc_n   <= 1'b1;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      keep_q  <= keep_d;
      dir_q   <= dir_d;
      cs_n    <= pins_d.cs_n;
      inc_n   <= pins_d.inc_n;
      done    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     up <= 1'b0;
    else if (up_en) up <= dir_q;
  end

  a_r10_strobe_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inc_n) |-> !cs_n);

  a_r3_dir_moves_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    (up != $past(up)) |-> (inc_n && $past(inc_n)));

  a_r5_release_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (inc_n == keep_q));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && inc_n));

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

// File: rtl/wiper_cmd_seq.sv
`timescale 1ns/1ps
module wiper_cmd_seq
  import wseq_pkg::*;
#(
  parameter int STEP_W        = 8,
  parameter int TAP_LAST      = 99,
  parameter int CS_LEAD_CYC   = 25,
  parameter int DIR_LEAD_CYC  = 725,
  parameter int STROBE_LO_CYC = 250,
  parameter int STROBE_HI_CYC = 250,
  parameter int REL_GAP_CYC   = 250,
  parameter int RECOVER_CYC   = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_up,
  input  logic              cmd_store,
  input  logic              cmd_home,
  output logic              done,
  output logic              pot_cs_n,
  output logic              pot_inc_n,
  output logic              pot_up
);

  localparam int LEN_MAX = wmax(wmax(wmax(CS_LEAD_CYC, DIR_LEAD_CYC),
                                     wmax(STROBE_LO_CYC, STROBE_HI_CYC)),
                                wmax(REL_GAP_CYC, RECOVER_CYC));
  localparam int TW = $clog2(LEN_MAX + 1);

  logic          rst_n_sync;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          steps_load;
  logic          steps_dec;
  logic          req_zero;
  logic          rem_zero;
  logic          rem_last;

  wseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  wseq_timer #(.CNT_W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  wseq_steps #(.STEP_W(STEP_W), .TAP_LAST(TAP_LAST)) u_steps (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .req_steps (cmd_steps),
    .req_home  (cmd_home),
    .load      (steps_load),
    .dec       (steps_dec),
    .req_zero  (req_zero),
    .rem_zero  (rem_zero),
    .rem_last  (rem_last)
  );

  wseq_fsm #(
    .TW            (TW),
    .CS_LEAD_CYC   (CS_LEAD_CYC),
    .DIR_LEAD_CYC  (DIR_LEAD_CYC),
    .STROBE_LO_CYC (STROBE_LO_CYC),
    .STROBE_HI_CYC (STROBE_HI_CYC),
    .REL_GAP_CYC   (REL_GAP_CYC),
    .RECOVER_CYC   (RECOVER_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cmd_valid   (cmd_valid),
    .cmd_up      (cmd_up),
    .cmd_store   (cmd_store),
    .cmd_home    (cmd_home),
    .req_zero    (req_zero),
    .tmr_expired (tmr_expired),
    .rem_zero    (rem_zero),
    .rem_last    (rem_last),
    .cmd_ready   (cmd_ready),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .steps_load  (steps_load),
    .steps_dec   (steps_dec),
    .done        (done),
    .cs_n        (pot_cs_n),
    .inc_n       (pot_inc_n),
    .up          (pot_up)
  );

endmodule

// File: tb/wiper_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module wiper_cmd_seq_tb_top;

  localparam int P_STEP_W = 8;
  localparam int P_TAP    = 99;
  localparam int P_CSS    = 2;
  localparam int P_DIRS   = 3;
  localparam int P_LOW    = 2;
  localparam int P_HIGH   = 3;
  localparam int P_HOLD   = 2;
  localparam int P_DESEL  = 4;

  typedef struct packed {
    logic [7:0] steps;
    logic       up;
    logic       store;
    logic       home;
    logic [7:0] pulses;
    logic [7:0] pos;
    logic [7:0] kept;
    logic       sel;
  } vec_t;

  // Model wiper starts at 50, kept value 50.
  localparam vec_t VEC [9] = '{
    '{8'd0,   1'b0, 1'b0, 1'b1, 8'd99, 8'd0,  8'd50, 1'b1}, // R7 homing
    '{8'd10,  1'b1, 1'b1, 1'b0, 8'd10, 8'd10, 8'd10, 1'b1},
    '{8'd5,   1'b1, 1'b0, 1'b0, 8'd5,  8'd15, 8'd10, 1'b1},
    '{8'd3,   1'b0, 1'b1, 1'b0, 8'd3,  8'd12, 8'd12, 1'b1},
    '{8'd200, 1'b1, 1'b0, 1'b0, 8'd99, 8'd99, 8'd12, 1'b1}, // R8 clipping
    '{8'd0,   1'b0, 1'b1, 1'b0, 8'd0,  8'd99, 8'd99, 1'b1}, // R9 zero with keep
    '{8'd0,   1'b0, 1'b0, 1'b0, 8'd0,  8'd99, 8'd99, 1'b0}, // R9 zero, discard
    '{8'd40,  1'b0, 1'b0, 1'b0, 8'd40, 8'd59, 8'd99, 1'b1},
    '{8'd7,   1'b1, 1'b1, 1'b1, 8'd99, 8'd0,  8'd99, 1'b1}  // R7 home overrides fields
  };

  logic                clk;
  logic                rst_n;
  logic                cmd_valid;
  logic                cmd_ready;
  logic [P_STEP_W-1:0] cmd_steps;
  logic                cmd_up;
  logic                cmd_store;
  logic                cmd_home;
  logic                done;
  logic                pot_cs_n;
  logic                pot_inc_n;
  logic                pot_up;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int pos_m = 50, kept_m = 50, falls = 0, sels = 0, dones = 0;
  int t_inc = 1000000, t_up = 1000000, t_csf = 1000000, t_csr = 1000000, t_edge = 1000000;
  int v_css = 0, v_dir = 0, v_dirchg = 0, v_low = 0, v_high = 0, v_hold = 0, v_gap = 0, v_fall = 0;
  logic p_cs = 1'b1, p_inc = 1'b1, p_up = 1'b0;

  wiper_cmd_seq #(
    .STEP_W(P_STEP_W), .TAP_LAST(P_TAP), .CS_LEAD_CYC(P_CSS), .DIR_LEAD_CYC(P_DIRS),
    .STROBE_LO_CYC(P_LOW), .STROBE_HI_CYC(P_HIGH), .REL_GAP_CYC(P_HOLD), .RECOVER_CYC(P_DESEL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_steps(cmd_steps), .cmd_up(cmd_up), .cmd_store(cmd_store), .cmd_home(cmd_home),
    .done(done), .pot_cs_n(pot_cs_n), .pot_inc_n(pot_inc_n), .pot_up(pot_up)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Pin-level potentiometer model with interval measurement.
  always @(negedge clk) begin
    if (!rst_n) begin
      p_cs = pot_cs_n; p_inc = pot_inc_n; p_up = pot_up;
    end else begin
      bit cs_fell, cs_rose, inc_fell, inc_rose, up_chg;
      if (t_inc  < 1000000) t_inc++;
      if (t_up   < 1000000) t_up++;
      if (t_csf  < 1000000) t_csf++;
      if (t_csr  < 1000000) t_csr++;
      if (t_edge < 1000000) t_edge++;
      cs_fell  = p_cs && !pot_cs_n;
      cs_rose  = !p_cs && pot_cs_n;
      inc_fell = p_inc && !pot_inc_n;
      inc_rose = !p_inc && pot_inc_n;
      up_chg   = (p_up != pot_up);
      if (up_chg) begin
        if (!p_inc || !pot_inc_n) v_dirchg++;
        t_up = 0;
      end
      if (cs_fell) begin
        sels++;
        if (t_csr < P_DESEL) v_gap++;
        t_csf = 0;
      end
      if (cs_rose) begin
        if (t_edge < P_HOLD) v_hold++;
        if (pot_inc_n) kept_m = pos_m;
        t_csr = 0;
      end
      if (inc_fell) begin
        if (pot_cs_n) v_fall++;
        else begin
          falls++;
          if (t_inc < P_HIGH) v_high++;
          if (t_up  < P_DIRS) v_dir++;
          if (t_csf < P_CSS)  v_css++;
          if (pot_up) begin if (pos_m < P_TAP) pos_m++; end
          else        begin if (pos_m > 0)     pos_m--; end
          t_edge = 0;
        end
      end
      if (inc_rose && !pot_cs_n) begin
        if (t_inc < P_LOW) v_low++;
        t_edge = 0;
      end
      if (inc_fell || inc_rose) t_inc = 0;
      if (done) dones++;
      p_cs = pot_cs_n; p_inc = pot_inc_n; p_up = pot_up;
    end
  end

  task automatic report;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic run_cmd(input vec_t v);
    @(negedge clk);
    cmd_steps = v.steps; cmd_up = v.up; cmd_store = v.store; cmd_home = v.home;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R2 ready low after accept", int'(cmd_ready), 0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_steps = '0;
    cmd_up = 1'b0; cmd_store = 1'b0; cmd_home = 1'b0;
    repeat (3) @(negedge clk);
    check(pot_cs_n == 1'b1 && pot_inc_n == 1'b1, "R1 select/strobe in reset",
          int'({pot_cs_n, pot_inc_n}), 3);
    check(pot_up == 1'b0 && done == 1'b0, "R1 up/done in reset", int'({pot_up, done}), 0);
    check(cmd_ready == 1'b1, "R1 ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pot_cs_n == 1'b1 && pot_inc_n == 1'b1 && done == 1'b0, "R1 idle after release",
          int'({pot_cs_n, pot_inc_n, done}), 6);

    for (int i = 0; i < 9; i++) begin
      int f0, s0, d0;
      f0 = falls; s0 = sels; d0 = dones;
      run_cmd(VEC[i]);
      check(falls - f0 == int'(VEC[i].pulses), $sformatf("R4 strobe count row %0d", i),
            falls - f0, int'(VEC[i].pulses));
      check(pos_m == int'(VEC[i].pos), $sformatf("R4 wiper position row %0d", i),
            pos_m, int'(VEC[i].pos));
      check(kept_m == int'(VEC[i].kept), $sformatf("R5 kept position row %0d", i),
            kept_m, int'(VEC[i].kept));
      check(sels - s0 == int'(VEC[i].sel), $sformatf("R9 select count row %0d", i),
            sels - s0, int'(VEC[i].sel));
      check(dones - d0 == 1, $sformatf("R6 done pulses row %0d", i), dones - d0, 1);
    end

    // Back-to-back: done of A and acceptance of B in the same cycle (R6, R2).
    @(negedge clk);
    cmd_steps = 8'd4; cmd_up = 1'b1; cmd_store = 1'b1; cmd_home = 1'b0; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_steps = 8'd2; cmd_up = 1'b0; cmd_store = 1'b0;
    check(cmd_ready == 1'b0, "R2 busy while command held", int'(cmd_ready), 0);
    while (!done) @(negedge clk);
    check(cmd_ready == 1'b1, "R6 ready in done cycle", int'(cmd_ready), 1);
    check(pos_m == 4, "R2 held command not taken early", pos_m, 4);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R2 held command taken at done", int'(cmd_ready), 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(pos_m == 2, "R4 back-to-back position", pos_m, 2);
    check(kept_m == 4, "R5 back-to-back kept", kept_m, 4);

    check(v_css == 0,    "R3 select lead violations", v_css, 0);
    check(v_dir == 0,    "R3 direction lead violations", v_dir, 0);
    check(v_dirchg == 0, "R3 direction change with strobe low", v_dirchg, 0);
    check(v_low == 0,    "R4 low width violations", v_low, 0);
    check(v_high == 0,   "R4 high width violations", v_high, 0);
    check(v_hold == 0,   "R5 release gap violations", v_hold, 0);
    check(v_gap == 0,    "R6 recovery gap violations", v_gap, 0);
    check(v_fall == 0,   "R10 strobe fall while deselected", v_fall, 0);
    finished = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
    end
  end

endmodule